// File: doc/BRIEF.md
# Variable Latency Carry Skip Adder

This block adds two 16-bit operands and a carry input, producing a 16-bit sum and a carry output. Internally the operands are cut into four 4-bit slices. Each slice is a small ripple-carry adder. A slice whose bits all propagate passes its incoming carry straight to the next slice through a bypass multiplexer.

Latency depends on the operands. A detector looks at the slice propagate flags for the operands presented with `start`. If no two neighbouring slices both propagate, no carry chain can run past the single-cycle budget. The result is then registered on the accepting edge, and `done` pulses in the following cycle.

If two neighbouring slices both propagate, the block takes a second cycle. The operands are held in registers, `busy` is raised for one cycle, and the sum is registered on the next edge. Any request that arrives during that busy cycle is dropped. The result is always the exact 17-bit sum in both cases, so only the timing differs.

Top module: `varlat_skip_adder`

The controller has two states:
- `ST_IDLE`: ready to accept work.
- `ST_EXTEND`: the second cycle of a long-chain addition.

Its transitions are:
- `IDLE_TO_EXTEND`: taken when `start` is high in `ST_IDLE` and the long-chain condition holds.
- `IDLE_STAY`: taken otherwise from `ST_IDLE`, and covers both a fast completion and no request.
- `EXTEND_TO_IDLE`: taken unconditionally after one cycle in `ST_EXTEND`.

## Requirements
- R1: Every completed addition presents `{cout, sum}` equal to the exact 17-bit value `a + b + cin` of the operands that were accepted with `start`.
- R2: Slice k covers bits [4k+3:4k] of the operands. A slice propagates when `a ^ b` is all ones within it. The long-chain condition holds exactly when slices k and k+1 both propagate, for some k in 0..2.
- R3: A start accepted in `ST_IDLE` without the long-chain condition gives `done` = 1 and `busy` = 0 in the cycle right after the accepting edge, with the result already on `sum`/`cout`.
- R4: A start accepted with the long-chain condition gives `busy` = 1 and `done` = 0 in the next cycle, then `done` = 1 and `busy` = 0 one cycle later. `busy` never lasts more than one cycle.
- R5: A `start` presented while `busy` is high is ignored. The pending result is still that of the first operands, and no extra `done` follows.
- R6: `done` is high only in the cycle that follows a completion edge. With no accepted start, `done` stays low.
- R7: `sum` and `cout` keep their value in every cycle in which `done` is low.
- R8: After reset, `sum` = 0, `cout` = 0, `done` = 0 and `busy` = 0.
- R9: A single propagating slice, or two propagating slices that are not neighbours (for example slices 0 and 2), completes in one cycle. This holds even with `cin` = 1 rippling through the propagating slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an addition of the present operands |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry input |
| sum | output | 16 | Registered sum |
| cout | output | 1 | Registered carry output |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High during the extra cycle of a long-chain addition |

## Verification
The bound checker holds several rules on every cycle:
- the exact 17-bit result for both fast and extended requests, judged from the operands seen at the accepting edge;
- the one-cycle limit on `busy` and the `done` that must follow it;
- the rule that `done` only follows an accepted request;
- the stability of the result between completions.

The bench's scenarios show the rest. It sweeps all sixteen slice-propagate patterns with both carry inputs, so that the latency decision is matched against the adjacency rule. It injects a competing request during the busy cycle. It drives the all-propagate operand pair with a carry in, and it records how many random additions took each latency.

// File: rtl/vlsa_pkg.sv
package vlsa_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_EXTEND = 1'b1
    } vlsa_state_t;

endpackage

// File: rtl/vlsa_slice.sv
// One slice: ripple-carry adder with a bypass multiplexer on its carry out.
module vlsa_slice #(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a_in,
    input  logic [SLICE_W-1:0] b_in,
    input  logic               c_in,
    output logic [SLICE_W-1:0] s_out,
    output logic               c_out,
    output logic               prop_all
);

    logic [SLICE_W-1:0] prop_bit;
    logic [SLICE_W-1:0] gen_bit;
    logic [SLICE_W:0]   ripple;

    assign ripple[0] = c_in;

    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        assign prop_bit[i]  = a_in[i] ^ b_in[i];
        assign gen_bit[i]   = a_in[i] & b_in[i];
        assign ripple[i+1]  = gen_bit[i] | (prop_bit[i] & ripple[i]);
        assign s_out[i]     = prop_bit[i] ^ ripple[i];
    end

    assign prop_all = &prop_bit;

    // Bypass: when every bit propagates, forward the incoming carry directly.
    always_comb begin
        if (prop_all) begin
            c_out = c_in;
        end else begin
            c_out = ripple[SLICE_W];
        end
    end

endmodule

// File: rtl/vlsa_core.sv
// Chain of slices with carry bypass; purely combinational.
module vlsa_core #(
    parameter int WIDTH   = 16,
    parameter int SLICE_W = 4
) (
    input  logic [WIDTH-1:0]             op_a,
    input  logic [WIDTH-1:0]             op_b,
    input  logic                         op_c,
    output logic [WIDTH-1:0]             res_sum,
    output logic                         res_carry,
    output logic [WIDTH/SLICE_W-1:0]     slice_prop
);

    localparam int NSLICE = WIDTH / SLICE_W;

    logic [NSLICE:0] carry_link;

    assign carry_link[0] = op_c;

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        vlsa_slice #(.SLICE_W(SLICE_W)) u_slice (
            .a_in     (op_a[k*SLICE_W +: SLICE_W]),
            .b_in     (op_b[k*SLICE_W +: SLICE_W]),
            .c_in     (carry_link[k]),
            .s_out    (res_sum[k*SLICE_W +: SLICE_W]),
            .c_out    (carry_link[k+1]),
            .prop_all (slice_prop[k])
        );
    end

    assign res_carry = carry_link[NSLICE];

endmodule

// File: rtl/vlsa_chain_detect.sv
// Flags operands whose carry could cross two neighbouring slices.
module vlsa_chain_detect #(
    parameter int NSLICE = 4
) (
    input  logic [NSLICE-1:0] slice_prop,
    output logic              long_chain
);

    logic [NSLICE-2:0] pair_hit;

    for (genvar k = 0; k < NSLICE - 1; k++) begin : g_pair
        assign pair_hit[k] = slice_prop[k] & slice_prop[k+1];
    end

    assign long_chain = |pair_hit;

endmodule

// File: rtl/vlsa_ctrl.sv
// Latency controller: idle, or one extra cycle for long carry chains.
module vlsa_ctrl
    import vlsa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        long_chain,
    output vlsa_state_t state_q,
    output logic        accept,
    output logic        finish,
    output logic        extend
);

    vlsa_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && long_chain) begin
                    state_d = ST_EXTEND;   // IDLE_TO_EXTEND
                end else begin
                    state_d = ST_IDLE;     // IDLE_STAY
                end
            end
            ST_EXTEND: begin
                state_d = ST_IDLE;         // EXTEND_TO_IDLE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        finish = 1'b0;
        extend = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = start;
                finish = start && !long_chain;
            end
            ST_EXTEND: begin
                finish = 1'b1;
                extend = 1'b1;
            end
            default: begin
                accept = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/varlat_skip_adder.sv
module varlat_skip_adder
    import vlsa_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int SLICE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             done,
    output logic             busy
);

    localparam int NSLICE = WIDTH / SLICE_W;

    vlsa_state_t      state_q;
    logic             accept;
    logic             finish;
    logic             extend;
    logic             long_chain;
    logic [WIDTH-1:0] held_a;
    logic [WIDTH-1:0] held_b;
    logic             held_c;
    logic [WIDTH-1:0] op_a;
    logic [WIDTH-1:0] op_b;
    logic             op_c;
    logic [WIDTH-1:0] core_sum;
    logic             core_carry;
    logic [NSLICE-1:0] slice_prop;

    // In the extra cycle the adder works on the held operands.
    always_comb begin
        if (extend) begin
            op_a = held_a;
            op_b = held_b;
            op_c = held_c;
        end else begin
            op_a = a;
            op_b = b;
            op_c = cin;
        end
    end

    vlsa_core #(.WIDTH(WIDTH), .SLICE_W(SLICE_W)) u_core (
        .op_a       (op_a),
        .op_b       (op_b),
        .op_c       (op_c),
        .res_sum    (core_sum),
        .res_carry  (core_carry),
        .slice_prop (slice_prop)
    );

    vlsa_chain_detect #(.NSLICE(NSLICE)) u_detect (
        .slice_prop (slice_prop),
        .long_chain (long_chain)
    );

    vlsa_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .long_chain (long_chain),
        .state_q    (state_q),
        .accept     (accept),
        .finish     (finish),
        .extend     (extend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_a <= '0;
            held_b <= '0;
            held_c <= 1'b0;
        end else if (accept) begin
            held_a <= a;
            held_b <= b;
            held_c <= cin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum  <= '0;
            cout <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                sum  <= core_sum;
                cout <= core_carry;
            end
        end
    end

    assign busy = (state_q == ST_EXTEND);

endmodule

// File: rtl/vlsa_checker.sv
module vlsa_checker #(
    parameter int WIDTH   = 16,
    parameter int SLICE_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             done,
    input logic             busy
);

    localparam int NSLICE = WIDTH / SLICE_W;

    function automatic logic chain_model(input logic [WIDTH-1:0] x,
                                         input logic [WIDTH-1:0] y);
        logic [WIDTH-1:0] px;
        logic hit;
        px  = x ^ y;
        hit = 1'b0;
        for (int k = 0; k < NSLICE - 1; k++) begin
            if ((&px[k*SLICE_W +: SLICE_W]) && (&px[(k+1)*SLICE_W +: SLICE_W])) begin
                hit = 1'b1;
            end
        end
        return hit;
    endfunction

    logic fast_req;
    logic slow_req;
    assign fast_req = start && !busy && !chain_model(a, b);
    assign slow_req = start && !busy &&  chain_model(a, b);

    assert_fast_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req |=> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{WIDTH{1'b0}}, $past(cin)})));

    assert_slow_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slow_req |-> ##2 ({cout, sum} == ({1'b0, $past(a, 2)} + {1'b0, $past(b, 2)} + {{WIDTH{1'b0}}, $past(cin, 2)})));

    assert_fast_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req |=> (done && !busy));

    assert_slow_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slow_req |=> (busy && !done));

    assert_busy_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && done));

    assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) || ($past(start) && !$past(busy))));

    assert_hold_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(sum) && $stable(cout)));

endmodule

bind varlat_skip_adder vlsa_checker #(.WIDTH(WIDTH), .SLICE_W(SLICE_W)) u_vlsa_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .done  (done),
    .busy  (busy)
);

// File: tb/varlat_skip_adder_tb.sv
module varlat_skip_adder_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         c_i = 1'b0;
    logic [W-1:0] sum;
    logic         cout;
    logic         done;
    logic         busy;

    int checks = 0;
    int errors = 0;
    int fast_cnt = 0;
    int slow_cnt = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    varlat_skip_adder #(.WIDTH(W), .SLICE_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .a(a_i), .b(b_i), .cin(c_i),
        .sum(sum), .cout(cout), .done(done), .busy(busy)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slice k is bits [4k+3:4k]; long chain when neighbouring slices both propagate.
    function automatic bit want_slow(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] p;
        bit r;
        p = x ^ y;
        r = 0;
        for (int k = 0; k < 3; k++)
            if (p[4*k +: 4] == 4'hF && p[4*(k+1) +: 4] == 4'hF) r = 1;
        return r;
    endfunction

    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input bit inject);
        logic [W:0] exp;
        bit slow;
        exp  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        slow = want_slow(x, y);
        @(negedge clk);
        a_i = x; b_i = y; c_i = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!slow) begin
            fast_cnt++;
            chk(done == 1'b1, "R3 fast done", done, 1);
            chk(busy == 1'b0, "R3 fast busy", busy, 0);
            chk({cout, sum} == exp, "R1 fast sum", {cout, sum}, exp);
        end else begin
            slow_cnt++;
            chk(busy == 1'b1, "R4 slow busy", busy, 1);
            chk(done == 1'b0, "R4 slow early done", done, 0);
            if (inject) begin
                a_i = ~x; b_i = x; c_i = ~c; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            chk(done == 1'b1, "R4 slow done", done, 1);
            chk(busy == 1'b0, "R4 busy one cycle", busy, 0);
            chk({cout, sum} == exp, inject ? "R5 sum kept after ignored start" : "R1 slow sum",
                {cout, sum}, exp);
            if (inject) begin
                @(negedge clk);
                chk(done == 1'b0, "R5 no extra done", done, 0);
                chk(busy == 1'b0, "R5 no extra busy", busy, 0);
                chk({cout, sum} == exp, "R7 sum held", {cout, sum}, exp);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sum == '0, "R8 sum reset", sum, 0);
        chk(cout == 1'b0, "R8 cout reset", cout, 0);
        chk(done == 1'b0, "R8 done reset", done, 0);
        chk(busy == 1'b0, "R8 busy reset", busy, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R6 no done without start", done, 0);

        // all-propagate operands with carry in: slow, wraps to 0x10000
        run_op(16'hFFFF, 16'h0000, 1'b1, 0);
        // R9: single propagating slice and non-neighbour slices are fast
        run_op(16'h000F, 16'h0000, 1'b1, 0);
        run_op(16'h0F0F, 16'h0000, 1'b1, 0);
        run_op(16'hF0F0, 16'h0000, 1'b1, 0);
        // R5: start during busy
        run_op(16'h00FF, 16'h0000, 1'b1, 1);
        run_op(16'hFF00, 16'h00FF, 1'b0, 1);

        // R2: all sixteen slice-propagate patterns, both carry values
        for (int pat = 0; pat < 16; pat++) begin
            for (int c = 0; c < 2; c++) begin
                logic [W-1:0] x, y;
                for (int k = 0; k < 4; k++) begin
                    x[4*k +: 4] = pat[k] ? 4'hA : 4'h3;
                    y[4*k +: 4] = pat[k] ? 4'h5 : 4'h3;
                end
                run_op(x, y, c[0], 0);
            end
        end

        // random sweep, R1 with mixed latencies
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] x, y;
            x = W'($urandom);
            y = (n % 3 == 0) ? ~x ^ W'($urandom_range(0, 15)) : W'($urandom);
            run_op(x, y, 1'($urandom), (n % 7 == 0));
            if (n % 5 == 0) begin
                logic [W:0] last;
                last = {cout, sum};
                @(negedge clk);
                chk(done == 1'b0, "R6 idle no done", done, 0);
                chk({cout, sum} == last, "R7 idle hold", {cout, sum}, last);
            end
        end

        chk(fast_cnt > 0, "R3 fast cases seen", fast_cnt, 1);
        chk(slow_cnt > 0, "R4 slow cases seen", slow_cnt, 1);
        $display("fast=%0d slow=%0d", fast_cnt, slow_cnt);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule